// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a ModRM byte of a 16-bit segmented processor into a memory address. It adds the base and index registers picked by the byte to an optional displacement, keeps the sum as a 16-bit offset, chooses the segment that the offset belongs to, and adds that segment's base to form a 20-bit physical address. It also reports the fixed cycle cost of the addressing mode, so that a sequencer can charge it.

A request starts with a one-cycle `start` strobe. The block captures the ModRM byte, the four address registers, the four segment register values and any prefix at that moment. It then pulls the displacement bytes it needs, from zero to two, off a valid/ready byte stream. One cycle after the last byte is accepted, or one cycle after capture when no byte is needed, it registers all results and pulses `done`. ModRM values that name a register operand are only flagged. They consume no bytes and form no address.

Top module: `seg_ea_gen`

## Requirements
- R1: For mod 00, 01 and 10 the r/m field picks the register terms: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. The offset is the sum of these terms and the displacement, truncated to 16 bits.
- R2: mod 00 with r/m 6 uses no register. Two stream bytes are taken, low byte first, and they form the offset directly.
- R3: mod 01 takes one stream byte and sign-extends it to 16 bits. mod 10 takes two stream bytes, low byte first. mod 00 with r/m other than 6 takes no byte and has no displacement.
- R4: `seg_idx` encodes ES=0, CS=1, SS=2, DS=3. An address that uses BP defaults to SS (r/m 2 and 3 in any memory mode, and r/m 6 with mod 01 or 10). Every other memory mode defaults to DS, including the direct form.
- R5: When `pfx_valid` is high at start and `pfx_byte` is 0x26, 0x2E, 0x36 or 0x3E, the segment becomes ES, CS, SS or DS respectively, replacing a DS or SS default. Any other prefix byte, or a low `pfx_valid`, leaves the default in place.
- R6: `phys` equals ((selected segment value × 16) + offset) mod 2^20.
- R7: `cycles` for mod 00 and r/m 0 to 7 is 7, 8, 8, 7, 5, 5, 6, 5. For mod 01 and mod 10 it is 11, 12, 12, 11, 9, 9, 9, 9.
- R8: A ModRM of 0xC0 or above sets `is_reg` and takes no stream byte. `offset`, `phys`, `cycles` and `seg_idx` then read 0.
- R9: `byt_ready` is high only while a request still owes displacement bytes. A byte is taken at a rising edge where `byt_valid` and `byt_ready` are both high. Stall cycles on `byt_valid` are tolerated, and `start` is ignored while `busy` is high.
- R10: `done` is a single-cycle pulse. With no stall cycles and N needed bytes, `done` first reads high N+2 clock periods after the period in which `start` is driven. The results hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (taken when not busy) |
| modrm | input | 8 | ModRM byte |
| pfx_valid | input | 1 | A segment prefix accompanies the request |
| pfx_byte | input | 8 | Prefix byte value |
| bx | input | 16 | BX register |
| bp | input | 16 | BP register |
| si | input | 16 | SI register |
| di | input | 16 | DI register |
| es_seg | input | 16 | ES segment register value |
| cs_seg | input | 16 | CS segment register value |
| ss_seg | input | 16 | SS segment register value |
| ds_seg | input | 16 | DS segment register value |
| byt_valid | input | 1 | Displacement byte offered |
| byt_data | input | 8 | Displacement byte |
| byt_ready | output | 1 | Block will take the offered byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Results updated this cycle |
| is_reg | output | 1 | ModRM named a register operand |
| offset | output | 16 | 16-bit effective offset |
| seg_idx | output | 2 | Selected segment (ES=0, CS=1, SS=2, DS=3) |
| phys | output | 20 | Physical address |
| cycles | output | 4 | Addressing-mode cycle cost |

## Verification
The bench sweeps all 256 ModRM values under no prefix, each of the four override bytes, and an unknown prefix byte. It also varies the register, segment and displacement values so that both the offset and the 20-bit sum overflow. A design that failed to truncate before adding the base would carry into bit 16 and land 64 KiB off. A design that missed the sign extension would place negative 8-bit displacements 256 bytes high. A design that treated the direct form as a BP mode would report SS where DS is expected. Stalled byte streams, an unknown prefix, a `start` strobe during a fetch, and register-mode ModRMs with bytes on offer check that nothing extra is consumed or latched. A wrong byte count or a mis-timed `done` shows as a latency or count mismatch.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;

  localparam int EA_MAXB   = 2;                    // most displacement bytes
  localparam int EA_CW     = $clog2(EA_MAXB + 1);  // byte counter width
  localparam int EA_COST_W = 4;                    // cycle cost width

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CALC  = 2'd2
  } ea_st_e;

  typedef struct packed {
    logic                 is_reg;
    logic                 direct;
    logic                 disp8;
    logic                 use_bx;
    logic                 use_bp;
    logic                 use_si;
    logic                 use_di;
    logic [EA_CW-1:0]     nbytes;
    seg_e                 dflt;
    logic [EA_COST_W-1:0] cost;
  } ea_dec_t;

  // Returns {hit, segment} for a prefix byte.
  function automatic logic [2:0] pfx_map(input logic [7:0] b);
    case (b)
      8'h26:   pfx_map = {1'b1, SEG_ES};
      8'h2E:   pfx_map = {1'b1, SEG_CS};
      8'h36:   pfx_map = {1'b1, SEG_SS};
      8'h3E:   pfx_map = {1'b1, SEG_DS};
      default: pfx_map = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/seg_ea_decode.sv
module seg_ea_decode
  import seg_ea_pkg::*;
(
  input  logic [7:0] modrm,
  output ea_dec_t    dec
);

  logic [1:0]           md;
  logic [2:0]           rm;
  logic [EA_COST_W-1:0] c_plain;

  always_comb begin
    md  = modrm[7:6];
    rm  = modrm[2:0];
    dec = '0;
    dec.dflt = SEG_DS;
    // base cost when there is no displacement (R7)
    if (!rm[2]) c_plain = (rm[0] ^ rm[1]) ? EA_COST_W'(8) : EA_COST_W'(7);
    else        c_plain = (rm == 3'd6)    ? EA_COST_W'(6) : EA_COST_W'(5);

    dec.is_reg = (modrm >= 8'hC0);        // R8
    if (!dec.is_reg) begin
      dec.direct = (md == 2'b00) && (rm == 3'd6);                 // R2
      dec.use_bx = (rm == 3'd0) || (rm == 3'd1) || (rm == 3'd7);  // R1
      dec.use_bp = (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && !dec.direct);
      dec.use_si = (rm == 3'd0) || (rm == 3'd2) || (rm == 3'd4);
      dec.use_di = (rm == 3'd1) || (rm == 3'd3) || (rm == 3'd5);
      dec.disp8  = (md == 2'b01);                                  // R3
      if (dec.direct || md == 2'b10) dec.nbytes = EA_CW'(2);
      else if (md == 2'b01)          dec.nbytes = EA_CW'(1);
      else                           dec.nbytes = EA_CW'(0);
      dec.dflt = dec.use_bp ? SEG_SS : SEG_DS;                     // R4
      if (md == 2'b00)  dec.cost = c_plain;
      else if (rm[2])   dec.cost = EA_COST_W'(9);
      else              dec.cost = c_plain + EA_COST_W'(4);
    end
  end

endmodule

// File: rtl/seg_ea_bytes.sv
module seg_ea_bytes
  import seg_ea_pkg::*;
#(
  parameter int NB = EA_MAXB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [EA_CW-1:0]  need,
  input  logic              fetch_en,
  input  logic              byt_valid,
  input  logic [7:0]        byt_data,
  output logic              byt_ready,
  output logic              last,
  output logic [8*NB-1:0]   disp
);

  logic [EA_CW-1:0]     cnt_q;
  logic [EA_CW-1:0]     need_q;
  logic [NB-1:0][7:0]   lane_q;
  logic                 take;

  assign byt_ready = fetch_en && (cnt_q != need_q);
  assign take      = byt_valid && byt_ready;
  assign last      = take && ((cnt_q + EA_CW'(1)) == need_q);
  assign disp      = lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      need_q <= '0;
    end else if (load) begin
      cnt_q  <= '0;
      need_q <= need;
    end else if (take) begin
      cnt_q  <= cnt_q + EA_CW'(1);
    end
  end

  // one register per displacement byte, filled low byte first
  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || load)                       lane_q[g] <= '0;
      else if (take && cnt_q == EA_CW'(g))   lane_q[g] <= byt_data;
    end
  end

  // R9: bytes are never taken beyond what the request owes
  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    take |-> (cnt_q < need_q))
    else $error("p_count_bound_r9");

endmodule

// File: rtl/seg_ea_form.sv
module seg_ea_form
  import seg_ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int PA_W      = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       calc,
  input  ea_dec_t                    dec,
  input  logic [OFS_W-1:0]           bx,
  input  logic [OFS_W-1:0]           bp,
  input  logic [OFS_W-1:0]           si,
  input  logic [OFS_W-1:0]           di,
  input  logic [OFS_W-1:0]           disp_raw,
  input  logic [3:0][SEG_W-1:0]      segs,
  input  logic                       ovr_v,
  input  seg_e                       ovr_seg,
  output logic                       done,
  output logic                       is_reg,
  output logic [OFS_W-1:0]           offset,
  output seg_e                       seg_idx,
  output logic [PA_W-1:0]            phys,
  output logic [EA_COST_W-1:0]       cycles
);

  localparam int EXT_W = OFS_W - 8;

  logic [OFS_W-1:0] dsp, regs_sum, ofs_n;
  seg_e             seg_n;
  logic [PA_W-1:0]  phys_n;

  always_comb begin
    if (dec.nbytes == '0)  dsp = '0;
    else if (dec.disp8)    dsp = {{EXT_W{disp_raw[7]}}, disp_raw[7:0]};   // R3
    else                   dsp = disp_raw;
    regs_sum = (dec.use_bx ? bx : '0) + (dec.use_bp ? bp : '0)
             + (dec.use_si ? si : '0) + (dec.use_di ? di : '0);
    ofs_n    = (dec.direct ? '0 : regs_sum) + dsp;                       // R1 wrap
    seg_n    = (ovr_v && (dec.dflt == SEG_DS || dec.dflt == SEG_SS)) ? ovr_seg : dec.dflt;
    phys_n   = (PA_W'(segs[seg_n]) << SEG_SHIFT) + PA_W'(ofs_n);         // R6
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      is_reg  <= 1'b0;
      offset  <= '0;
      seg_idx <= SEG_ES;
      phys    <= '0;
      cycles  <= '0;
    end else begin
      done <= calc;
      if (calc) begin
        is_reg <= dec.is_reg;
        if (dec.is_reg) begin                                            // R8
          offset  <= '0;
          seg_idx <= SEG_ES;
          phys    <= '0;
          cycles  <= '0;
        end else begin
          offset  <= ofs_n;
          seg_idx <= seg_n;
          phys    <= phys_n;
          cycles  <= dec.cost;
        end
      end
    end
  end

  // R6: the base is a multiple of 16, so the low nibble comes from the offset
  p_low_nibble_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (phys[SEG_SHIFT-1:0] == offset[SEG_SHIFT-1:0]))
    else $error("p_low_nibble_r6");

  // R7: memory modes cost between 5 and 12 cycles
  p_cost_range_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !is_reg) |-> (cycles >= EA_COST_W'(5) && cycles <= EA_COST_W'(12)))
    else $error("p_cost_range_r7");

  // R8: register operands report no address and no cost
  p_reg_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (done && is_reg) |-> (offset == '0 && phys == '0 && cycles == '0))
    else $error("p_reg_zero_r8");

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int PA_W      = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [7:0]             modrm,
  input  logic                   pfx_valid,
  input  logic [7:0]             pfx_byte,
  input  logic [OFS_W-1:0]       bx,
  input  logic [OFS_W-1:0]       bp,
  input  logic [OFS_W-1:0]       si,
  input  logic [OFS_W-1:0]       di,
  input  logic [SEG_W-1:0]       es_seg,
  input  logic [SEG_W-1:0]       cs_seg,
  input  logic [SEG_W-1:0]       ss_seg,
  input  logic [SEG_W-1:0]       ds_seg,
  input  logic                   byt_valid,
  input  logic [7:0]             byt_data,
  output logic                   byt_ready,
  output logic                   busy,
  output logic                   done,
  output logic                   is_reg,
  output logic [OFS_W-1:0]       offset,
  output logic [1:0]             seg_idx,
  output logic [PA_W-1:0]        phys,
  output logic [EA_COST_W-1:0]   cycles
);

  localparam int DISP_W = 8 * EA_MAXB;

  ea_st_e               st_q;
  logic                 accept, last;
  logic [7:0]           modrm_q, modrm_sel;
  logic [OFS_W-1:0]     bx_q, bp_q, si_q, di_q;
  logic [3:0][SEG_W-1:0] segs_q;
  logic                 ovr_v_q;
  seg_e                 ovr_seg_q;
  logic [2:0]           pfx_hit;
  ea_dec_t              dec;
  logic [DISP_W-1:0]    disp;
  seg_e                 seg_w;

  assign accept    = start && (st_q == ST_IDLE);          // R9
  assign modrm_sel = (st_q == ST_IDLE) ? modrm : modrm_q;
  assign pfx_hit   = pfx_map(pfx_byte);
  assign busy      = (st_q != ST_IDLE);
  assign seg_idx   = seg_w;

  seg_ea_decode u_dec (
    .modrm (modrm_sel),
    .dec   (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      modrm_q   <= '0;
      bx_q      <= '0;
      bp_q      <= '0;
      si_q      <= '0;
      di_q      <= '0;
      segs_q    <= '0;
      ovr_v_q   <= 1'b0;
      ovr_seg_q <= SEG_ES;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          modrm_q   <= modrm;
          bx_q      <= bx;
          bp_q      <= bp;
          si_q      <= si;
          di_q      <= di;
          segs_q    <= {ds_seg, ss_seg, cs_seg, es_seg};
          ovr_v_q   <= pfx_valid && pfx_hit[2];             // R5
          ovr_seg_q <= seg_e'(pfx_hit[1:0]);
          st_q      <= (dec.nbytes == '0) ? ST_CALC : ST_FETCH;
        end
        ST_FETCH: if (last) st_q <= ST_CALC;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  seg_ea_bytes #(.NB(EA_MAXB)) u_bytes (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .need      (dec.nbytes),
    .fetch_en  (st_q == ST_FETCH),
    .byt_valid (byt_valid),
    .byt_data  (byt_data),
    .byt_ready (byt_ready),
    .last      (last),
    .disp      (disp)
  );

  seg_ea_form #(
    .OFS_W     (OFS_W),
    .SEG_W     (SEG_W),
    .PA_W      (PA_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_form (
    .clk      (clk),
    .rst      (rst),
    .calc     (st_q == ST_CALC),
    .dec      (dec),
    .bx       (bx_q),
    .bp       (bp_q),
    .si       (si_q),
    .di       (di_q),
    .disp_raw (OFS_W'(disp)),
    .segs     (segs_q),
    .ovr_v    (ovr_v_q),
    .ovr_seg  (ovr_seg_q),
    .done     (done),
    .is_reg   (is_reg),
    .offset   (offset),
    .seg_idx  (seg_w),
    .phys     (phys),
    .cycles   (cycles)
  );

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("p_done_pulse_r10");

  // R9: no byte is requested while idle
  p_idle_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !byt_ready)
    else $error("p_idle_no_ready_r9");

  // R9: a stalled stream keeps the request open
  p_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (byt_ready && !byt_valid) |=> byt_ready)
    else $error("p_ready_hold_r9");

  // R5: ES or CS on a memory address only ever comes from a prefix
  p_es_cs_needs_prefix_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !is_reg && (seg_idx == 2'd0 || seg_idx == 2'd1)) |-> ovr_v_q)
    else $error("p_es_cs_needs_prefix_r5");

endmodule

// File: tb/test_seg_ea_gen.sv
module test_seg_ea_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  modrm = '0;
  logic        pfx_valid = 1'b0;
  logic [7:0]  pfx_byte = '0;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0;
  logic [15:0] es_seg = '0, cs_seg = '0, ss_seg = '0, ds_seg = '0;
  logic        byt_valid = 1'b0;
  logic [7:0]  byt_data = '0;
  logic        byt_ready, busy, done, is_reg;
  logic [15:0] offset;
  logic [1:0]  seg_idx;
  logic [19:0] phys;
  logic [3:0]  cycles;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [7:0]  d0, d1;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_ea_gen i_seg_ea_gen (
    .clk(clk), .rst(rst), .start(start), .modrm(modrm),
    .pfx_valid(pfx_valid), .pfx_byte(pfx_byte),
    .bx(bx), .bp(bp), .si(si), .di(di),
    .es_seg(es_seg), .cs_seg(cs_seg), .ss_seg(ss_seg), .ds_seg(ds_seg),
    .byt_valid(byt_valid), .byt_data(byt_data), .byt_ready(byt_ready),
    .busy(busy), .done(done), .is_reg(is_reg), .offset(offset),
    .seg_idx(seg_idx), .phys(phys), .cycles(cycles)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic randomize_state();
    logic [31:0] a;
    a = rnd(); bx = a[15:0]; bp = a[31:16];
    a = rnd(); si = a[15:0]; di = a[31:16];
    a = rnd(); es_seg = a[15:0]; cs_seg = a[31:16];
    a = rnd(); ss_seg = a[15:0]; ds_seg = a[31:16];
    a = rnd(); d0 = a[7:0]; d1 = a[15:8];
  endtask

  // expected byte count from mod and r/m (R2, R3, R8)
  function automatic int exp_need(input logic [7:0] m);
    if (m >= 8'hC0) return 0;
    if (m[7:6] == 2'b01) return 1;
    if (m[7:6] == 2'b10) return 2;
    if (m[2:0] == 3'd6) return 2;
    return 0;
  endfunction

  task automatic run_op(input logic [7:0] m, input bit pv, input logic [7:0] pb,
                        input bit gap, input bit poke);
    logic [1:0]  md;
    logic [2:0]  rm;
    logic [15:0] e_ofs, e_disp, e_regs, e_segv;
    logic [1:0]  e_seg;
    logic [19:0] e_phys;
    logic [3:0]  e_cost;
    bit          e_reg, bp_used, r;
    int          need, idx, lat, n;
    md = m[7:6]; rm = m[2:0];
    e_reg = (m >= 8'hC0);
    need = exp_need(m);
    // register terms (R1)
    case (rm)
      3'd0: e_regs = bx + si;
      3'd1: e_regs = bx + di;
      3'd2: e_regs = bp + si;
      3'd3: e_regs = bp + di;
      3'd4: e_regs = si;
      3'd5: e_regs = di;
      3'd6: e_regs = (md == 2'b00) ? 16'h0 : bp;
      default: e_regs = bx;
    endcase
    if (need == 2)      e_disp = {d1, d0};
    else if (need == 1) e_disp = {{8{d0[7]}}, d0};
    else                e_disp = 16'h0;
    e_ofs = e_regs + e_disp;
    bp_used = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'b00);
    e_seg = bp_used ? 2'd2 : 2'd3;                                       // R4
    if (pv) begin                                                        // R5
      case (pb)
        8'h26: e_seg = 2'd0;
        8'h2E: e_seg = 2'd1;
        8'h36: e_seg = 2'd2;
        8'h3E: e_seg = 2'd3;
        default: ;
      endcase
    end
    case (e_seg)
      2'd0: e_segv = es_seg;
      2'd1: e_segv = cs_seg;
      2'd2: e_segv = ss_seg;
      default: e_segv = ds_seg;
    endcase
    e_phys = 20'({4'h0, e_segv} << 4) + 20'(e_ofs);                      // R6
    case (rm)
      3'd0, 3'd3: e_cost = (md == 2'b00) ? 4'd7 : 4'd11;                 // R7
      3'd1, 3'd2: e_cost = (md == 2'b00) ? 4'd8 : 4'd12;
      3'd6:       e_cost = (md == 2'b00) ? 4'd6 : 4'd9;
      default:    e_cost = (md == 2'b00) ? 4'd5 : 4'd9;
    endcase
    if (e_reg) begin e_ofs = 0; e_phys = 0; e_cost = 0; e_seg = 0; end  // R8

    @(negedge clk);
    modrm = m; pfx_valid = pv; pfx_byte = pb; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; idx = 0; n = 0;
    while (!done && n < 40) begin
      if (poke && n == 0) begin start = 1'b1; modrm = 8'h01; end         // R9 ignored start
      else start = 1'b0;
      r = byt_ready;
      if (gap && (n % 2 == 0)) byt_valid = 1'b0;
      else begin
        byt_valid = 1'b1;
        byt_data = (idx == 0) ? d0 : (idx == 1) ? d1 : 8'hEE;
      end
      if (r && byt_valid) idx++;
      @(negedge clk);
      lat++; n++;
    end
    start = 1'b0; byt_valid = 1'b0; modrm = m;
    chk(done === 1'b1, "R10 done seen", {31'h0, done}, 1);
    if (e_reg) chk(is_reg === 1'b1 && idx == 0, "R8 register mode flag/bytes", {is_reg, 7'h0, 8'(idx)}, 32'h0000_0100 >> 1 << 1 | 0 );
    else       chk(is_reg === 1'b0, "R8 memory mode flag", {31'h0, is_reg}, 0);
    chk(idx == need, "R9 bytes consumed", idx, need);
    if (need == 2 && md == 2'b00) chk(offset === e_ofs, "R2 direct offset", offset, e_ofs);
    else if (need != 0)           chk(offset === e_ofs, "R3 displaced offset", offset, e_ofs);
    else                          chk(offset === e_ofs, "R1 register offset", offset, e_ofs);
    chk(seg_idx === e_seg, pv ? "R5 segment with prefix" : "R4 default segment", seg_idx, e_seg);
    chk(phys === e_phys, "R6 physical address", phys, e_phys);
    chk(cycles === e_cost, "R7 cycle cost", cycles, e_cost);
    if (!gap) chk(lat == need + 2, "R10 latency", lat, need + 2);
    @(negedge clk);
    chk(done === 1'b0, "R10 single pulse", {31'h0, done}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pbs [0:5];
    pbs[0] = 8'h26; pbs[1] = 8'h26; pbs[2] = 8'h2E;
    pbs[3] = 8'h36; pbs[4] = 8'h3E; pbs[5] = 8'h3F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && byt_ready === 1'b0, "R9 reset idle",
        {29'h0, done, busy, byt_ready}, 0);
    chk(offset === 16'h0 && phys === 20'h0 && cycles === 4'h0 && is_reg === 1'b0,
        "R10 reset outputs", {offset, cycles, 11'h0, is_reg}, 0);

    // directed: offset wrap and 20-bit wrap (R1, R6)
    randomize_state();
    bx = 16'hFFF0; ds_seg = 16'hFFFF; d0 = 8'h0F; d1 = 8'h00;
    run_op(8'h87, 1'b0, 8'h00, 1'b0, 1'b0);
    bx = 16'hFFFF; si = 16'h0003;
    run_op(8'h00, 1'b0, 8'h00, 1'b0, 1'b0);
    // directed: negative 8-bit displacement (R3)
    si = 16'h0005; d0 = 8'hF0;
    run_op(8'h44, 1'b0, 8'h00, 1'b0, 1'b0);
    // directed: direct offset stays on DS, override to ES (R2, R4, R5)
    d0 = 8'h34; d1 = 8'h12;
    run_op(8'h06, 1'b0, 8'h00, 1'b0, 1'b0);
    run_op(8'h06, 1'b1, 8'h26, 1'b1, 1'b0);
    // directed: start during fetch is ignored (R9)
    run_op(8'h96, 1'b0, 8'h00, 1'b0, 1'b1);

    // sweep of every ModRM value under each prefix situation
    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0] mb;
        bit g, pk;
        mb = 8'(m);
        randomize_state();
        g  = mb[3] ^ p[0];
        pk = (exp_need(mb) == 2) && mb[4] && (p == 1);
        run_op(mb, p != 0, pbs[p], g, pk);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule